// File: doc/BRIEF.md
# Edge Event Sense and Interrupt Controller

This block watches a vector of already-debounced input channels and records events on them. Each channel is given its own trigger type: any change of level, a low-to-high transition only, or a high-to-low transition only. A transition is found by comparing each input with the value it had on the previous clock. When a channel's enable bit is set, a detected event sets that channel's pending flag. The flag then stays set until software writes a one to that bit.

A single global enable merges all enabled pending flags into one level-sensitive interrupt request. Software can also poll the pending flags with the interrupt turned off. The register port is a plain single-cycle write strobe with a combinational read. The read data follows the address.

Software can issue a reset by writing a register. This soft reset clears the event configuration and the pending flags but keeps the global interrupt enable. Only the hardware reset input clears the global interrupt enable.

Top module: `evt_sense_irq`

## Requirements
- R1: After hardware reset the pending flags, the event enables, both mode words and the global interrupt enable all read zero, and `irq` is low.
- R2: A channel with mode code 00 flags any change of level. Code 11 is reserved and behaves exactly like 00. An enabled channel's pending bit reads one on the first read after the clock edge that first sees the new input level.
- R3: A channel with mode code 01 flags only a 0-to-1 transition. A 1-to-0 transition leaves its pending bit clear.
- R4: A channel with mode code 10 flags only a 1-to-0 transition. A 0-to-1 transition leaves its pending bit clear.
- R5: A transition on a channel whose enable bit is zero sets no pending bit. Setting the enable bit later does not record that earlier transition.
- R6: Writing the pending address clears each pending bit whose write-data bit is one. Bits written as zero keep their value.
- R7: When a new event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R8: `irq` is high exactly when bit 0 of the interrupt-enable register is one and at least one pending bit has its enable bit set. It stays high until every such bit is cleared or masked.
- R9: Pending flags are set and readable while bit 0 of the interrupt-enable register is zero, and `irq` then stays low.
- R10: Writing a one to bit 0 at the soft-reset address clears the pending flags, the enables and both mode words on that clock edge, and keeps the interrupt-enable register. A hardware reset clears the interrupt-enable register.
- R11: The level address reads the present value of `din`.
- R12: Register map by word address: 0 input level (read-only); 1 event enable; 2 mode word for channels 0 to N_CH/2-1; 3 mode word for the upper half; 4 pending; 5 interrupt enable (bit 0); 6 soft reset (reads zero); 7 reads zero. In a mode word, channel i uses bits 2i+1:2i of the word, with i counted from the first channel of that half. Writes to addresses 0 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| din | input | N_CH | Debounced channel levels |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| addr | input | 3 | Word address for write and read |
| wdata | input | N_CH | Write data |
| rdata | output | N_CH | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with the default N_CH of 32. This means the top channel and the channel in the upper mode word at an offset inside that word are both exercised. Channel 31 checks the most significant pending bit. Channel 20 checks the field placement in the upper mode word, which a 16-channel build would not reach with the same mode word layout. The full 32-bit write data also lets one write clear every pending bit at once.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_LEVEL   = 3'd0,
        RA_ENABLE  = 3'd1,
        RA_MODE_LO = 3'd2,
        RA_MODE_HI = 3'd3,
        RA_PEND    = 3'd4,
        RA_IRQEN   = 3'd5,
        RA_SWRST   = 3'd6,
        RA_SPARE   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRIG_ANY  = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RSV  = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    function automatic edge_pair_t edges_of(input logic prev, input logic cur);
        edge_pair_t e;
        e.rise = ~prev & cur;
        e.fall = prev & ~cur;
        return e;
    endfunction

    function automatic logic trig_hit(input trig_mode_e m, input edge_pair_t e);
        logic hit;
        unique case (m)
            TRIG_RISE: hit = e.rise;
            TRIG_FALL: hit = e.fall;
            default:   hit = e.rise | e.fall;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/evt_edge_detect.sv
module evt_edge_detect
    import evt_pkg::*;
#(
    parameter int N_CH = 32
) (
    input  logic                clk,
    input  logic [N_CH-1:0]     din,
    input  logic [2*N_CH-1:0]   mode_vec,
    output logic [N_CH-1:0]     evt_raw
);

    logic [N_CH-1:0] din_prev;

    always_ff @(posedge clk) begin
        din_prev <= din;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        edge_pair_t ep;
        assign ep         = edges_of(din_prev[g], din[g]);
        assign evt_raw[g] = trig_hit(trig_mode_e'(mode_vec[2*g +: 2]), ep);
    end

endmodule

// File: rtl/evt_pending.sv
module evt_pending #(
    parameter int N_CH = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            swrst,
    input  logic [N_CH-1:0] set_vec,
    input  logic [N_CH-1:0] clr_vec,
    output logic [N_CH-1:0] pend_q
);

    always_ff @(posedge clk) begin
        if (rst || swrst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
    import evt_pkg::*;
#(
    parameter int N_CH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [N_CH-1:0]     wdata,
    input  logic [N_CH-1:0]     din,
    input  logic [N_CH-1:0]     pend_q,
    output logic [N_CH-1:0]     enable_q,
    output logic [2*N_CH-1:0]   mode_q,
    output logic                irq_en_q,
    output logic                swrst,
    output logic [N_CH-1:0]     clr_vec,
    output logic [N_CH-1:0]     rdata
);

    reg_addr_e ra;
    assign ra = reg_addr_e'(addr);

    assign swrst   = wr_en && (ra == RA_SWRST) && wdata[0];
    assign clr_vec = (wr_en && (ra == RA_PEND)) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            mode_q   <= '0;
            irq_en_q <= 1'b0;
        end else if (swrst) begin
            enable_q <= '0;
            mode_q   <= '0;
        end else if (wr_en) begin
            unique case (ra)
                RA_ENABLE:  enable_q           <= wdata;
                RA_MODE_LO: mode_q[N_CH-1:0]   <= wdata;
                RA_MODE_HI: mode_q[2*N_CH-1:N_CH] <= wdata;
                RA_IRQEN:   irq_en_q           <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (ra)
            RA_LEVEL:   rdata = din;
            RA_ENABLE:  rdata = enable_q;
            RA_MODE_LO: rdata = mode_q[N_CH-1:0];
            RA_MODE_HI: rdata = mode_q[2*N_CH-1:N_CH];
            RA_PEND:    rdata = pend_q;
            RA_IRQEN:   rdata[0] = irq_en_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_sense_irq.sv
module evt_sense_irq
    import evt_pkg::*;
#(
    parameter int N_CH = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_CH-1:0]             din,
    input  logic                        wr_en,
    input  logic [evt_pkg::ADDR_W-1:0]  addr,
    input  logic [N_CH-1:0]             wdata,
    output logic [N_CH-1:0]             rdata,
    output logic                        irq
);

    logic [N_CH-1:0]   enable_q;
    logic [2*N_CH-1:0] mode_q;
    logic              irq_en_q;
    logic              swrst;
    logic [N_CH-1:0]   clr_vec;
    logic [N_CH-1:0]   pend_q;
    logic [N_CH-1:0]   evt_raw;
    logic [N_CH-1:0]   evt_hit;

    evt_regfile #(.N_CH(N_CH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .din      (din),
        .pend_q   (pend_q),
        .enable_q (enable_q),
        .mode_q   (mode_q),
        .irq_en_q (irq_en_q),
        .swrst    (swrst),
        .clr_vec  (clr_vec),
        .rdata    (rdata)
    );

    evt_edge_detect #(.N_CH(N_CH)) u_edges (
        .clk      (clk),
        .din      (din),
        .mode_vec (mode_q),
        .evt_raw  (evt_raw)
    );

    assign evt_hit = evt_raw & enable_q;

    evt_pending #(.N_CH(N_CH)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .swrst   (swrst),
        .set_vec (evt_hit),
        .clr_vec (clr_vec),
        .pend_q  (pend_q)
    );

    assign irq = irq_en_q && (|(pend_q & enable_q));

endmodule

// File: rtl/evt_sense_irq_chk.sv
module evt_sense_irq_chk #(
    parameter int N_CH = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [2:0]      addr,
    input logic [N_CH-1:0] wdata,
    input logic            irq,
    input logic [N_CH-1:0] pend_q,
    input logic [N_CH-1:0] enable_q,
    input logic            irq_en_q,
    input logic [N_CH-1:0] evt_hit,
    input logic            swrst
);

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_q == '0 && enable_q == '0 && !irq_en_q && !irq));

    a_r5_no_pend_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_q & ~$past(pend_q) & ~$past(enable_q)) == '0));

    a_r6_ones_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd4) |=> ((pend_q & $past(wdata) & ~$past(evt_hit)) == '0));

    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        (!swrst && evt_hit != '0) |=> ((($past(evt_hit)) & ~pend_q) == '0));

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en_q);

    a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_en) |=> irq);

    a_r10_swrst_clears: assert property (@(posedge clk) disable iff (rst)
        swrst |=> (pend_q == '0 && enable_q == '0));

    a_r10_swrst_keeps_irqen: assert property (@(posedge clk) disable iff (rst)
        swrst |=> $stable(irq_en_q));

endmodule

bind evt_sense_irq evt_sense_irq_chk #(.N_CH(N_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .pend_q   (pend_q),
    .enable_q (enable_q),
    .irq_en_q (irq_en_q),
    .evt_hit  (evt_hit),
    .swrst    (swrst)
);

// File: tb/tb_evt_sense_irq.sv
module tb_evt_sense_irq;

    localparam int  N_CH      = 32;
    localparam time CLK_PER   = 10ns;
    localparam logic [2:0] A_LEVEL = 3'd0, A_EN = 3'd1, A_MLO = 3'd2, A_MHI = 3'd3,
                           A_PEND = 3'd4, A_IRQEN = 3'd5, A_SWRST = 3'd6, A_SPARE = 3'd7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N_CH-1:0] din = '0;
    logic            wr_en = 1'b0;
    logic [2:0]      addr = '0;
    logic [N_CH-1:0] wdata = '0;
    logic [N_CH-1:0] rdata;
    logic            irq;

    int n_chk = 0;
    int n_bad = 0;

    evt_sense_irq #(.N_CH(N_CH)) dut (
        .clk(clk), .rst(rst), .din(din), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string req, input logic [N_CH-1:0] act, input logic [N_CH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N_CH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N_CH-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_din(input logic [N_CH-1:0] v);
        @(negedge clk);
        din = v;
        @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [N_CH-1:0] exp);
        logic [N_CH-1:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic clean();
        set_din('0);
        wr(A_SWRST, 32'h1);
    endtask

    task automatic t_reset();
        chk_reg("R1 pend", A_PEND, '0);
        chk_reg("R1 enable", A_EN, '0);
        chk_reg("R1 mode lo", A_MLO, '0);
        chk_reg("R1 mode hi", A_MHI, '0);
        chk_reg("R1 irqen", A_IRQEN, '0);
        chk("R1 irq", {31'd0, irq}, '0);
    endtask

    task automatic t_any_change();
        clean();
        wr(A_EN, '1);
        set_din(32'h8000_0001);
        chk_reg("R2 rise ch0 ch31", A_PEND, 32'h8000_0001);
        wr(A_PEND, '1);
        set_din(32'h8000_0000);
        chk_reg("R2 fall ch0", A_PEND, 32'h0000_0001);
        set_din('0);
        wr(A_PEND, '1);
        wr(A_MLO, 32'h0000_00C0);
        wr(A_EN, 32'h8);
        set_din(32'h8);
        chk_reg("R2 code 11 rise ch3", A_PEND, 32'h8);
        wr(A_PEND, '1);
        set_din('0);
        chk_reg("R2 code 11 fall ch3", A_PEND, 32'h8);
    endtask

    task automatic t_rise();
        clean();
        wr(A_MLO, 32'h0000_4000);
        wr(A_EN, 32'h80);
        set_din(32'h80);
        chk_reg("R3 rise ch7", A_PEND, 32'h80);
        wr(A_PEND, '1);
        set_din('0);
        chk_reg("R3 fall ignored ch7", A_PEND, '0);
    endtask

    task automatic t_fall();
        clean();
        wr(A_MHI, 32'h0000_0200);
        wr(A_EN, 32'h0010_0000);
        set_din(32'h0010_0000);
        chk_reg("R4 rise ignored ch20", A_PEND, '0);
        set_din('0);
        chk_reg("R4 fall ch20", A_PEND, 32'h0010_0000);
    endtask

    task automatic t_disabled();
        clean();
        wr(A_EN, 32'h1);
        set_din(32'h2);
        chk_reg("R5 disabled ch1", A_PEND, '0);
        wr(A_EN, 32'h3);
        chk_reg("R5 no late record", A_PEND, '0);
        set_din('0);
        chk_reg("R5 enabled ch1", A_PEND, 32'h2);
    endtask

    task automatic t_w1c();
        clean();
        wr(A_EN, 32'h3);
        set_din(32'h3);
        wr(A_PEND, '0);
        chk_reg("R6 zero write", A_PEND, 32'h3);
        wr(A_PEND, 32'h1);
        chk_reg("R6 clear bit0", A_PEND, 32'h2);
        wr(A_PEND, 32'h2);
        chk_reg("R6 clear bit1", A_PEND, '0);
    endtask

    task automatic t_collide();
        clean();
        wr(A_EN, 32'h4);
        set_din(32'h4);
        @(negedge clk);
        din = '0; wr_en = 1'b1; addr = A_PEND; wdata = 32'h4;
        @(negedge clk);
        wr_en = 1'b0;
        chk_reg("R7 event beats clear", A_PEND, 32'h4);
    endtask

    task automatic t_irq();
        clean();
        wr(A_EN, 32'h3);
        set_din(32'h3);
        chk_reg("R9 poll pend", A_PEND, 32'h3);
        chk("R9 irq low", {31'd0, irq}, '0);
        wr(A_IRQEN, 32'h1);
        chk("R8 irq high", {31'd0, irq}, 32'h1);
        wr(A_PEND, 32'h1);
        chk("R8 irq held", {31'd0, irq}, 32'h1);
        wr(A_PEND, 32'h2);
        chk("R8 irq drops", {31'd0, irq}, '0);
        set_din(32'h1);
        chk("R8 irq again", {31'd0, irq}, 32'h1);
        wr(A_EN, 32'h1);
        chk("R8 irq masked", {31'd0, irq}, '0);
        chk_reg("R8 pend kept", A_PEND, 32'h2);
    endtask

    task automatic t_swrst();
        clean();
        chk_reg("R10 irqen kept by clean", A_IRQEN, 32'h1);
        wr(A_EN, 32'hF);
        wr(A_MLO, 32'h55);
        wr(A_MHI, 32'h55);
        set_din(32'h1);
        chk("R10 irq before", {31'd0, irq}, 32'h1);
        wr(A_SWRST, 32'h1);
        chk_reg("R10 pend", A_PEND, '0);
        chk_reg("R10 enable", A_EN, '0);
        chk_reg("R10 mode lo", A_MLO, '0);
        chk_reg("R10 mode hi", A_MHI, '0);
        chk_reg("R10 irqen", A_IRQEN, 32'h1);
        chk("R10 irq after", {31'd0, irq}, '0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        chk_reg("R10 hw clears irqen", A_IRQEN, '0);
    endtask

    task automatic t_map();
        clean();
        set_din(32'hA5A5_0F0F);
        chk_reg("R11 level", A_LEVEL, 32'hA5A5_0F0F);
        wr(A_LEVEL, 32'hFFFF_FFFF);
        wr(A_SPARE, 32'hFFFF_FFFF);
        chk_reg("R12 level read-only", A_LEVEL, 32'hA5A5_0F0F);
        chk_reg("R12 spare zero", A_SPARE, '0);
        chk_reg("R12 swrst reads zero", A_SWRST, '0);
        chk_reg("R12 no side write", A_EN, '0);
        chk_reg("R12 irqen untouched", A_IRQEN, '0);
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_any_change();
        t_rise();
        t_fall();
        t_disabled();
        t_w1c();
        t_collide();
        t_irq();
        t_swrst();
        t_map();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule